// File: doc/BRIEF.md
# Enabled-Channel Sample Stream Packer

This block gathers one set of simultaneously captured converter samples, one per channel, on a single sample strobe. It then streams the samples of the channels that are switched on, one word at a time, over one 16-bit output bus with a valid/ready handshake. Each converter value is unsigned offset binary. It goes out left-justified in the output word, and the spare low bits are zero. Channels that are switched off produce no word, so the length of each burst follows the enable mask.

The enable mask comes from a neighbouring control register block. It is taken in at the same strobe as the samples, so one burst always reflects a single mask. The final word of each burst carries an end marker, which lets a downstream consumer frame the burst without knowing the mask. If a new strobe arrives while a burst is still outstanding, the new set is discarded. A sticky overrun flag then records the loss until reset.

Top module: `sspk_top`

## Requirements
- R1: After a synchronous active-low reset, `out_valid_o`, `out_last_o` and `overrun_o` are all 0.
- R2: When a strobe is seen while no burst is outstanding, all channel samples present at that clock edge are captured together, and `out_valid_o` rises in the following cycle if at least one channel is enabled.
- R3: Each output word is the 14-bit offset-binary sample shifted left by two with bits 1:0 zero. Sample 0x0000 gives 0x0000, 0x2000 gives 0x8000 and 0x3FFF gives 0xFFFC.
- R4: Words of one burst appear in ascending channel order (channel 0 first). Channel i is included only if bit i of `chan_en_i` was 1 at the strobe.
- R5: `out_last_o` is 1 exactly on the word of the highest enabled channel of the burst. After that word is accepted, `out_valid_o` is 0 in the next cycle.
- R6: A strobe seen while no burst is outstanding and with an all-zero mask emits no word and does not raise the overrun flag.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o`, `out_word_o` and `out_last_o` hold their values into the next cycle.
- R8: A strobe seen while a burst is outstanding is dropped. This includes the cycle in which its last word is accepted. The dropped strobe sets `overrun_o` in the next cycle, and `overrun_o` then stays 1 until reset. The outstanding burst continues unchanged.
- R9: Changes to `chan_en_i` after the capturing strobe have no effect on the burst in flight.
- R10: Changes to `smp_data_i` after the capturing strobe have no effect on the words of the burst in flight.
- R11: With `out_ready_i` held at 1, a burst of N words is delivered on N consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_strobe_i | input | 1 | One-cycle pulse: all channel samples are valid |
| smp_data_i | input | NUM_CH*SAMPLE_W | Channel samples, channel i at bits i*SAMPLE_W upward |
| chan_en_i | input | NUM_CH | Channel enable mask, bit i for channel i |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer accepts the word this cycle |
| out_word_o | output | WORD_W | Left-justified offset-binary sample |
| out_last_o | output | 1 | Word is the final one of its burst |
| overrun_o | output | 1 | Sticky: a strobe was dropped |

## Verification
The bench builds the block with its default parameters: eight channels, 14-bit samples and 16-bit words. With eight channels, every one of the 256 possible masks can be swept, from the empty mask through single channels to the full set. The two-bit pad makes the code end points 0x0000, 0x8000 and 0xFFFC directly observable. A behavioural queue model is compared every cycle while the ready line is randomised and strobes are deliberately placed against outstanding bursts, including the cycle that accepts the final word.

// File: rtl/sspk_pkg.sv
// Package: sspk_pkg
// Holds the default geometry of the sample stream packer. The top level and
// its submodules take their parameter defaults from here, so that one edit
// keeps them consistent.
package sspk_pkg;
    localparam int unsigned SSPK_NUM_CH   = 8;   // channels captured per strobe
    localparam int unsigned SSPK_SAMPLE_W = 14;  // converter sample width
    localparam int unsigned SSPK_WORD_W   = 16;  // output bus width
endpackage

// File: rtl/sspk_capture.sv
// Module: sspk_capture
// Purpose: holds one formatted output word per channel, all loaded together
// on a single load pulse, so that every channel reflects the same instant.
// Assumes: WORD_W >= SAMPLE_W. The sample is offset binary and is placed in
// the top SAMPLE_W bits of the word. Any spare low bits are zero.
module sspk_capture
    import sspk_pkg::*;
#(
    parameter int unsigned NUM_CH   = SSPK_NUM_CH,
    parameter int unsigned SAMPLE_W = SSPK_SAMPLE_W,
    parameter int unsigned WORD_W   = SSPK_WORD_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
    output logic [NUM_CH*WORD_W-1:0]   words_o
);
    localparam int unsigned PAD_W = WORD_W - SAMPLE_W;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic [WORD_W-1:0] fmt_word;
        logic [WORD_W-1:0] word_q;

        // Left-justify the sample; the variant depends on whether a pad exists.
        if (PAD_W > 0) begin : g_pad
            assign fmt_word = {samples_i[ch*SAMPLE_W +: SAMPLE_W], {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign fmt_word = samples_i[ch*SAMPLE_W +: SAMPLE_W];
        end

        // Per-channel holding register, loaded only on an accepted strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (load_i) begin
                word_q <= fmt_word;
            end
        end

        assign words_o[ch*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/sspk_sequencer.sv
// Module: sspk_sequencer
// Purpose: keeps the set of channels still to be sent in the current burst.
// It accepts a new burst only when idle, retires the lowest pending channel
// on each handshake, and flags strobes that arrive while busy.
// Assumes: advance_i is only asserted while busy_o is 1.
module sspk_sequencer
    import sspk_pkg::*;
#(
    parameter int unsigned NUM_CH = SSPK_NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [NUM_CH-1:0] mask_i,
    input  logic              advance_i,
    output logic              load_o,
    output logic              busy_o,
    output logic [NUM_CH-1:0] pending_o,
    output logic              overrun_o
);
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] lowest;
    logic              ovr_q;

    // Busy while any channel of the current burst is still unsent.
    assign busy_o = |pend_q;

    // A strobe is taken only when nothing is outstanding.
    assign load_o = strobe_i & ~busy_o;

    // Isolate the lowest pending channel (the next one to be retired).
    assign lowest = pend_q & (~pend_q + 1'b1);

    // Pending-set register: load the mask on an accepted strobe, shrink on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (load_o) begin
            pend_q <= mask_i;
        end else if (advance_i) begin
            pend_q <= pend_q & ~lowest;
        end
    end

    // Sticky overrun: set by any strobe seen while a burst is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (strobe_i && busy_o) begin
            ovr_q <= 1'b1;
        end
    end

    assign pending_o = pend_q;
    assign overrun_o = ovr_q;

    // R8: the overrun flag never clears outside reset.
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R8: a strobe against an outstanding burst raises the flag next cycle.
    p_drop_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && busy_o) |=> overrun_o);

    // R8: a dropped strobe leaves the outstanding set untouched.
    p_drop_keeps_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && busy_o && !advance_i) |=> $stable(pend_q));

    // R4: each handshake retires exactly one channel.
    p_retire_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i |=> ($countones(pend_q) + 1 == $countones($past(pend_q))));
endmodule

// File: rtl/sspk_picker.sv
// Module: sspk_picker
// Purpose: selects the word of the lowest pending channel, reports its
// channel index, and marks it as last when no other channel is pending.
// Assumes: the pending set and the words come from registers, so the
// outputs are stable for a whole cycle.
module sspk_picker
    import sspk_pkg::*;
#(
    parameter int unsigned NUM_CH = SSPK_NUM_CH,
    parameter int unsigned WORD_W = SSPK_WORD_W
) (
    input  logic [NUM_CH-1:0]        pending_i,
    input  logic [NUM_CH*WORD_W-1:0] words_i,
    output logic [WORD_W-1:0]        word_o,
    output logic [$clog2(NUM_CH > 1 ? NUM_CH : 2)-1:0] index_o,
    output logic                     last_o
);
    localparam int unsigned IDX_W = $clog2(NUM_CH > 1 ? NUM_CH : 2);

    logic [NUM_CH-1:0] sel;

    // One-hot select of the lowest pending channel.
    assign sel = pending_i & (~pending_i + 1'b1);

    // AND-OR multiplexer driven by the one-hot select.
    always_comb begin
        word_o  = '0;
        index_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel[i]) begin
                word_o  = word_o | words_i[i*WORD_W +: WORD_W];
                index_o = IDX_W'(i);
            end
        end
    end

    // Last word when the selected channel is the only one still pending.
    assign last_o = (|pending_i) && ((pending_i & ~sel) == '0);
endmodule

// File: rtl/sspk_top.sv
// Module: sspk_top
// Purpose: packs the enabled channels of one simultaneous sample set into a
// valid/ready word stream in ascending channel order, with an end marker
// and a sticky overrun flag for strobes that arrive while a burst is busy.
// Assumes: smp_strobe_i is synchronous to clk. The mask is taken at the strobe.
module sspk_top
    import sspk_pkg::*;
#(
    parameter int unsigned NUM_CH   = SSPK_NUM_CH,
    parameter int unsigned SAMPLE_W = SSPK_SAMPLE_W,
    parameter int unsigned WORD_W   = SSPK_WORD_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_strobe_i,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data_i,
    input  logic [NUM_CH-1:0]          chan_en_i,
    output logic                       out_valid_o,
    input  logic                       out_ready_i,
    output logic [WORD_W-1:0]          out_word_o,
    output logic                       out_last_o,
    output logic                       overrun_o
);
    localparam int unsigned IDX_W = $clog2(NUM_CH > 1 ? NUM_CH : 2);

    logic                     load;
    logic                     busy;
    logic                     advance;
    logic [NUM_CH-1:0]        pending;
    logic [NUM_CH*WORD_W-1:0] words;
    logic [IDX_W-1:0]         cur_index;

    // Handshake completes when a valid word meets ready.
    assign advance     = out_valid_o & out_ready_i;
    assign out_valid_o = busy;

    sspk_sequencer #(
        .NUM_CH   (NUM_CH)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (smp_strobe_i),
        .mask_i    (chan_en_i),
        .advance_i (advance),
        .load_o    (load),
        .busy_o    (busy),
        .pending_o (pending),
        .overrun_o (overrun_o)
    );

    sspk_capture #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W),
        .WORD_W   (WORD_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .samples_i (smp_data_i),
        .words_o   (words)
    );

    sspk_picker #(
        .NUM_CH (NUM_CH),
        .WORD_W (WORD_W)
    ) u_pick (
        .pending_i (pending),
        .words_i   (words),
        .word_o    (out_word_o),
        .index_o   (cur_index),
        .last_o    (out_last_o)
    );

    // R7: a stalled word holds still.
    p_hold_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=>
            (out_valid_o && $stable(out_word_o) && $stable(out_last_o)));

    // R5: accepting the last word ends the burst.
    p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && out_last_o) |=> !out_valid_o);

    // R4: within a burst, channel indices strictly ascend.
    p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && !out_last_o) |=>
            (out_valid_o && (cur_index > $past(cur_index))));

    // R2: an accepted strobe with a non-empty mask starts a burst next cycle.
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_strobe_i && !out_valid_o && (|chan_en_i)) |=> out_valid_o);

    // R6: an empty mask on an idle strobe emits nothing and flags nothing.
    p_empty_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_strobe_i && !out_valid_o && (chan_en_i == '0) && !overrun_o) |=>
            (!out_valid_o && !overrun_o));

    // R5: the end marker only appears on a valid word.
    p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);
endmodule

// File: tb/sspk_top_bench.sv
// Bench: queue-based reference model of the packer, compared on every cycle.
module sspk_top_bench;
    localparam int NCH = 8;
    localparam int SW  = 14;
    localparam int WW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_strobe_i = 1'b0;
    logic [NCH*SW-1:0] smp_data_i = '0;
    logic [NCH-1:0]    chan_en_i = '0;
    logic              out_valid_o;
    logic              out_ready_i = 1'b0;
    logic [WW-1:0]     out_word_o;
    logic              out_last_o;
    logic              overrun_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // Reference model state.
    int q_word[$];
    bit q_last[$];
    bit m_ovr = 1'b0;

    sspk_top #(.NUM_CH(NCH), .SAMPLE_W(SW), .WORD_W(WW)) u_sspk_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_strobe_i (smp_strobe_i),
        .smp_data_i   (smp_data_i),
        .chan_en_i    (chan_en_i),
        .out_valid_o  (out_valid_o),
        .out_ready_i  (out_ready_i),
        .out_word_o   (out_word_o),
        .out_last_o   (out_last_o),
        .overrun_o    (overrun_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL [%s] %s: actual 0x%0h expected 0x%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Model: behaviour at each edge, written from the requirements.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q_word.delete();
            q_last.delete();
            m_ovr = 1'b0;
        end else begin
            automatic bit busy = (q_word.size() != 0);
            if (busy && out_ready_i) begin
                void'(q_word.pop_front());
                void'(q_last.pop_front());
            end
            if (smp_strobe_i) begin
                if (busy) begin
                    m_ovr = 1'b1;                       // R8
                end else begin
                    automatic int hi = -1;
                    for (int c = 0; c < NCH; c++) if (chan_en_i[c]) hi = c;
                    for (int c = 0; c < NCH; c++) begin
                        if (chan_en_i[c]) begin         // R4, R9
                            q_word.push_back(int'(smp_data_i[c*SW +: SW]) << 2); // R3, R10
                            q_last.push_back(c == hi);  // R5
                        end
                    end
                end
            end
        end
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL [watchdog] run did not end: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit ev = (q_word.size() != 0);
            chk(cur_req, "valid", int'(out_valid_o), int'(ev));       // R11, R2
            if (ev && out_valid_o) begin
                chk(cur_req, "word", int'(out_word_o), q_word[0]);    // R3, R4
                chk(cur_req, "last", int'(out_last_o), int'(q_last[0])); // R5
            end
            chk(cur_req, "overrun", int'(overrun_o), int'(m_ovr));    // R8, R6
        end
    end

    task automatic pulse(input logic [NCH-1:0] m, input logic [NCH*SW-1:0] d);
        @(negedge clk);
        chan_en_i = m;
        smp_data_i = d;
        smp_strobe_i = 1'b1;
        @(negedge clk);
        smp_strobe_i = 1'b0;
    endtask

    task automatic drain(input bit rnd);
        while (q_word.size() != 0) begin
            @(negedge clk);
            out_ready_i = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1", "valid in reset", int'(out_valid_o), 0);
        chk("R1", "last in reset", int'(out_last_o), 0);
        chk("R1", "overrun in reset", int'(overrun_o), 0);
        rst_n = 1'b1;
    endtask

    function automatic logic [NCH*SW-1:0] rnd_set();
        logic [NCH*SW-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*SW +: SW] = SW'($urandom());
        return v;
    endfunction

    initial begin
        logic [NCH*SW-1:0] s;
        do_reset();

        // R3: code end points and midscale, with ready held high.
        cur_req = "R3";
        out_ready_i = 1'b1;
        s = rnd_set();
        s[0*SW +: SW] = 14'h0000;
        s[1*SW +: SW] = 14'h2000;
        s[2*SW +: SW] = 14'h3FFF;
        pulse(8'hFF, s);
        drain(1'b0);

        // R11 and R2: full burst with ready high, one word per cycle.
        cur_req = "R11";
        pulse(8'hFF, rnd_set());
        drain(1'b0);

        // R6: empty mask produces nothing.
        cur_req = "R6";
        pulse(8'h00, rnd_set());
        repeat (4) @(negedge clk);

        // R4, R5, R7: every mask with random back-pressure.
        for (int m = 0; m < 256; m++) begin
            cur_req = (m % 3 == 0) ? "R7" : ((m % 3 == 1) ? "R4" : "R5");
            pulse(NCH'(m), rnd_set());
            drain(1'b1);
        end

        // R9 and R10: change mask and samples after the strobe while stalled.
        cur_req = "R9";
        out_ready_i = 1'b0;
        pulse(8'hA5, rnd_set());
        chan_en_i = 8'h5A;
        cur_req = "R10";
        smp_data_i = rnd_set();
        repeat (4) @(negedge clk);
        drain(1'b0);

        // R8: strobe against a stalled burst.
        cur_req = "R8";
        out_ready_i = 1'b0;
        pulse(8'h0F, rnd_set());
        @(negedge clk);
        pulse(8'hF0, rnd_set());
        repeat (3) @(negedge clk);
        drain(1'b0);
        repeat (5) @(negedge clk);

        // R8: strobe in the same cycle as the final handshake.
        do_reset();
        cur_req = "R8";
        out_ready_i = 1'b1;
        @(negedge clk);
        chan_en_i = 8'h01;
        smp_data_i = rnd_set();
        smp_strobe_i = 1'b1;
        repeat (2) @(negedge clk);
        smp_strobe_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8", "overrun after final-word collision", int'(overrun_o), 1);

        // Free-running mix of strobes and back-pressure.
        cur_req = "R8";
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            out_ready_i = 1'($urandom_range(0, 3) != 0);
            smp_strobe_i = ($urandom_range(0, 9) == 0);
            chan_en_i = NCH'($urandom());
            smp_data_i = rnd_set();
        end
        smp_strobe_i = 1'b0;
        drain(1'b0);

        do_reset();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule